// File: doc/BRIEF.md
# Pointer Address Generator with Circular Wrap

This block forms the effective address of a register-indirect load or store and the updated pointer value that goes back to the register file. A pointer comes from one of two register files (side A or side B), selected by a side bit and a register number. An offset, either a full register value or a small unsigned constant, is scaled by the access size. It is then added to or subtracted from the pointer in one of six forms: offset only, pre-modify or post-modify, each in both directions.

Four pointer registers on each side (numbers 4 to 7) can be set to wrap inside a power-of-two block instead of counting linearly. A 32-bit mode word holds a 2-bit mode field for each of these eight registers and two 5-bit block-size fields. All other registers always modify linearly. The result is registered, so the address, the new pointer value and the write-back enable appear one cycle after the request.

Top module: `ptr_addr_gen`

## Requirements
- R1: Outputs are registered. `valid_o` is `valid_i` delayed by one clock, and `addr_o`, `base_new_o`, `wb_en_o` and `rsvd_mode_o` belong to the request of the previous cycle. `wb_en_o` and `rsvd_mode_o` are low in any cycle where `valid_o` is low.
- R2: While `rst_ni` is low, all outputs are zero.
- R3: `mod_i` codes 0 (plus offset) and 1 (minus offset) give `addr_o` = pointer ± scaled offset, `wb_en_o`=0 and `base_new_o` equal to the unchanged pointer. Codes 6 and 7 behave like code 0.
- R4: Codes 2 (pre-increment) and 3 (pre-decrement) give `addr_o` = `base_new_o` = the modified pointer, with `wb_en_o`=1.
- R5: Codes 4 (post-increment) and 5 (post-decrement) give `addr_o` = the old pointer, `base_new_o` = the modified pointer, with `wb_en_o`=1.
- R6: `size_i` 0/1/2/3 (byte/half/word/double) shifts the offset left by 0/1/2/3 bits. When `use_imm_i`=1 the offset is the 5-bit `imm_i`, zero-extended.
- R7: Registers with numbers outside 4..7 modify linearly on either side, whatever the mode word holds, and never raise `rsvd_mode_o`.
- R8: The mode field of side A register 4+k sits at mode-word bits [2k+1:2k]. The mode field of side B register 4+k sits at bits [2k+9:2k+8]. Field value 00 selects linear modification, and the fields of other registers have no effect.
- R9: Field value 01 selects circular mode with N taken from mode-word bits [20:16].
- R10: Field value 10 selects circular mode with N taken from mode-word bits [25:21].
- R11: In circular mode the block is 2^(N+1) bytes. Result bits N..0 come from the sum or difference, and all higher bits keep the pointer's value. N=31 wraps the whole 32-bit address.
- R12: Field value 11 modifies linearly and sets `rsvd_mode_o` for that one request only.
- R13: Mode-word bits [31:26] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| side_i | input | 1 | Register file of the pointer: 0 = A, 1 = B |
| reg_idx_i | input | 5 | Register number of the pointer |
| base_i | input | 32 | Current pointer value |
| off_reg_i | input | 32 | Register offset value |
| imm_i | input | 5 | Unsigned constant offset |
| use_imm_i | input | 1 | 1 selects `imm_i` as the offset |
| size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| mod_i | input | 3 | Modifier form, codes as in R3 to R5 |
| mode_word_i | input | 32 | Mode fields and block sizes |
| valid_o | output | 1 | Result present |
| addr_o | output | 32 | Effective address |
| base_new_o | output | 32 | Pointer value to write back |
| wb_en_o | output | 1 | Write `base_new_o` to the pointer register |
| rsvd_mode_o | output | 1 | Reserved mode field used |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 5-bit register numbers and constants, four wrap-capable pointers per side, and 5-bit block-size fields. With these values the largest constant (31, giving 248 bytes after double-word scaling) and both extremes of the block size can be reached. N=0 gives a 2-byte block, and N=31 wraps the full 32-bit range. Vectors cover pointers on both sides and at both edges of the wrap-capable range, with mode words that load neighbouring fields and the unused block-size field with values that would give a different result if they were decoded.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;

  typedef enum logic [2:0] {
    MOD_ADD      = 3'd0,
    MOD_SUB      = 3'd1,
    MOD_PRE_INC  = 3'd2,
    MOD_PRE_DEC  = 3'd3,
    MOD_POST_INC = 3'd4,
    MOD_POST_DEC = 3'd5
  } mod_e;

  typedef enum logic [1:0] {
    AM_LIN   = 2'd0,
    AM_CIRC0 = 2'd1,
    AM_CIRC1 = 2'd2,
    AM_RSVD  = 2'd3
  } amode_e;

endpackage

// File: rtl/ptr_mode_dec.sv
module ptr_mode_dec
  import ptr_addr_pkg::*;
#(
  parameter int RIDX_W       = 5,
  parameter int PTR_LO       = 4,
  parameter int PTR_PER_SIDE = 4,
  localparam int SLOTS       = 2 * PTR_PER_SIDE,
  localparam int FIELD_BITS  = 2 * SLOTS
) (
  input  logic                  side_i,
  input  logic [RIDX_W-1:0]     reg_idx_i,
  input  logic [FIELD_BITS-1:0] fields_i,
  output amode_e                mode_o
);

  logic [SLOTS-1:0] hit;
  logic [1:0]       sel [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic         SLOT_SIDE = (s >= PTR_PER_SIDE);
    localparam int           SLOT_REG  = PTR_LO + (s % PTR_PER_SIDE);
    assign hit[s] = (side_i == SLOT_SIDE) && (int'(reg_idx_i) == SLOT_REG);
    assign sel[s] = hit[s] ? fields_i[2*s +: 2] : 2'b00;
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int s = 0; s < SLOTS; s++) acc = acc | sel[s];
    mode_o = amode_e'(acc);
  end

  // at most one slot can match a register
  always_comb a_r8_one_slot: assert ($onehot0(hit));

endmodule

// File: rtl/ptr_off_scale.sv
module ptr_off_scale #(
  parameter int AW    = 32,
  parameter int IMM_W = 5
) (
  input  logic [AW-1:0]    off_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic [1:0]       size_i,
  output logic [AW-1:0]    scaled_o
);

  logic [AW-1:0] raw;

  assign raw      = use_imm_i ? {{(AW-IMM_W){1'b0}}, imm_i} : off_reg_i;
  assign scaled_o = raw << size_i;

endmodule

// File: rtl/ptr_wrap_add.sv
module ptr_wrap_add #(
  parameter int AW   = 32,
  parameter int BK_W = 5
) (
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   delta_i,
  input  logic            sub_i,
  input  logic            circ_i,
  input  logic [BK_W-1:0] bk_n_i,
  output logic [AW-1:0]   result_o
);

  logic [AW-1:0] mask;
  logic [AW-1:0] sum;

  // block of 2^(N+1) bytes: bits N..0 wrap
  always_comb begin
    for (int i = 0; i < AW; i++)
      mask[i] = !circ_i || (i <= int'(bk_n_i));
  end

  assign sum      = sub_i ? (base_i - delta_i) : (base_i + delta_i);
  assign result_o = (base_i & ~mask) | (sum & mask);

endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_pkg::*;
#(
  parameter int AW           = 32,
  parameter int RIDX_W       = 5,
  parameter int IMM_W        = 5,
  parameter int BK_W         = 5,
  parameter int PTR_LO       = 4,
  parameter int PTR_PER_SIDE = 4,
  parameter int MW_W         = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              side_i,
  input  logic [RIDX_W-1:0] reg_idx_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     off_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        mod_i,
  input  logic [MW_W-1:0]   mode_word_i,
  output logic              valid_o,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     base_new_o,
  output logic              wb_en_o,
  output logic              rsvd_mode_o
);

  localparam int SLOTS      = 2 * PTR_PER_SIDE;
  localparam int FIELD_BITS = 2 * SLOTS;
  localparam int BK0_LSB    = FIELD_BITS;
  localparam int BK1_LSB    = FIELD_BITS + BK_W;
  localparam int USED_BITS  = BK1_LSB + BK_W;

  amode_e          mode;
  logic [BK_W-1:0] bk_n;
  logic            circ;
  logic [AW-1:0]   scaled;
  logic [AW-1:0]   moved;
  logic            is_pre, is_post, is_sub;
  logic [AW-1:0]   addr_d, base_d;

  logic unused_mw_hi;
  assign unused_mw_hi = ^mode_word_i[MW_W-1:USED_BITS];

  ptr_mode_dec #(
    .RIDX_W      (RIDX_W),
    .PTR_LO      (PTR_LO),
    .PTR_PER_SIDE(PTR_PER_SIDE)
  ) u_dec (
    .side_i   (side_i),
    .reg_idx_i(reg_idx_i),
    .fields_i (mode_word_i[FIELD_BITS-1:0]),
    .mode_o   (mode)
  );

  ptr_off_scale #(.AW(AW), .IMM_W(IMM_W)) u_scale (
    .off_reg_i(off_reg_i),
    .imm_i    (imm_i),
    .use_imm_i(use_imm_i),
    .size_i   (size_i),
    .scaled_o (scaled)
  );

  assign circ = (mode == AM_CIRC0) || (mode == AM_CIRC1);
  assign bk_n = (mode == AM_CIRC1) ? mode_word_i[BK1_LSB +: BK_W]
                                   : mode_word_i[BK0_LSB +: BK_W];

  assign is_pre  = (mod_i == MOD_PRE_INC)  || (mod_i == MOD_PRE_DEC);
  assign is_post = (mod_i == MOD_POST_INC) || (mod_i == MOD_POST_DEC);
  assign is_sub  = (mod_i == MOD_SUB) || (mod_i == MOD_PRE_DEC) ||
                   (mod_i == MOD_POST_DEC);

  ptr_wrap_add #(.AW(AW), .BK_W(BK_W)) u_add (
    .base_i  (base_i),
    .delta_i (scaled),
    .sub_i   (is_sub),
    .circ_i  (circ),
    .bk_n_i  (bk_n),
    .result_o(moved)
  );

  assign addr_d = is_post ? base_i : moved;
  assign base_d = (is_pre || is_post) ? moved : base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      addr_o      <= '0;
      base_new_o  <= '0;
      wb_en_o     <= 1'b0;
      rsvd_mode_o <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      wb_en_o     <= valid_i && (is_pre || is_post);
      rsvd_mode_o <= valid_i && (mode == AM_RSVD);
      if (valid_i) begin
        addr_o     <= addr_d;
        base_new_o <= base_d;
      end
    end
  end

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_en_o && !rsvd_mode_o));
  a_r3_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_pre && !is_post) |=> (!wb_en_o && base_new_o == $past(base_i)));
  a_r4_pre_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_pre) |=> (wb_en_o && addr_o == base_new_o));
  a_r5_post_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_post) |=> (wb_en_o && addr_o == $past(base_i)));
  a_r7_no_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (int'(reg_idx_i) < PTR_LO || int'(reg_idx_i) >= PTR_LO + PTR_PER_SIDE))
      |=> !rsvd_mode_o);

endmodule

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic        side;
    logic [4:0]  idx;
    logic [31:0] base;
    logic [31:0] offr;
    logic [4:0]  imm;
    logic        use_imm;
    logic [1:0]  size;
    logic [2:0]  mod;
    logic [31:0] mw;
    logic [31:0] e_addr;
    logic [31:0] e_base;
    logic        e_wb;
    logic        e_rsvd;
    logic [3:0]  req;
  } vec_t;

  // side idx base offr imm use size mod mw  | addr base wb rsvd req
  localparam vec_t VECS [NV] = '{
    // R7: ineligible reg, all-ones mode word, linear
    '{1'b0, 5'd1, 32'h1000, 32'h0, 5'd3, 1'b1, 2'd2, 3'd0, 32'hFFFF_FFFF,
      32'h100C, 32'h1000, 1'b0, 1'b0, 4'd7},
    // R8 R4: A4 linear pre-dec, byte reg offset
    '{1'b0, 5'd4, 32'h2000, 32'h10, 5'd0, 1'b0, 2'd0, 3'd3, 32'h0,
      32'h1FF0, 32'h1FF0, 1'b1, 1'b0, 4'd8},
    // R6 R5: A4 post-inc, imm 31 double -> 248
    '{1'b0, 5'd4, 32'h3000, 32'h0, 5'd31, 1'b1, 2'd3, 3'd4, 32'h0,
      32'h3000, 32'h30F8, 1'b1, 1'b0, 4'd6},
    // R9: A5 circ BK0 N=3 (16B)
    '{1'b0, 5'd5, 32'h100C, 32'h0, 5'd2, 1'b1, 2'd2, 3'd4, 32'h0003_0004,
      32'h100C, 32'h1004, 1'b1, 1'b0, 4'd9},
    // R10: B7 circ BK1 N=4 (32B), BK0 decoy
    '{1'b1, 5'd7, 32'h2004, 32'h3, 5'd0, 1'b0, 2'd1, 3'd3, 32'h0081_8000,
      32'h201E, 32'h201E, 1'b1, 1'b0, 4'd10},
    // R12: B4 mode 11 -> linear + flag
    '{1'b1, 5'd4, 32'h00FC, 32'h0, 5'd4, 1'b1, 2'd2, 3'd2, 32'h0002_0300,
      32'h010C, 32'h010C, 1'b1, 1'b1, 4'd12},
    // R13: reserved top bits set, A6 linear sub
    '{1'b0, 5'd6, 32'h0500, 32'h0, 5'd1, 1'b1, 2'd0, 3'd1, 32'hFC00_0000,
      32'h04FF, 32'h0500, 1'b0, 1'b0, 4'd13},
    // R11: A7 circ N=31 full wrap, post-dec
    '{1'b0, 5'd7, 32'h0004, 32'h0, 5'd2, 1'b1, 2'd3, 3'd5, 32'h001F_0040,
      32'h0004, 32'hFFFF_FFF4, 1'b1, 1'b0, 4'd11},
    // R11: B5 circ N=0 (2B), plus offset
    '{1'b1, 5'd5, 32'h7001, 32'h0, 5'd1, 1'b1, 2'd0, 3'd0, 32'h0000_0400,
      32'h7000, 32'h7001, 1'b0, 1'b0, 4'd11},
    // R3: mod code 7 acts as plus offset
    '{1'b0, 5'd1, 32'h0010, 32'h20, 5'd0, 1'b0, 2'd1, 3'd7, 32'h0,
      32'h0050, 32'h0010, 1'b0, 1'b0, 4'd3},
    // R8: B6 field 00 linear while A6 field is circular
    '{1'b1, 5'd6, 32'h1007, 32'h0, 5'd1, 1'b1, 2'd2, 3'd2, 32'h0002_0010,
      32'h100B, 32'h100B, 1'b1, 1'b0, 4'd8},
    // R10: B4 circ BK1 N=1 (4B), post-inc
    '{1'b1, 5'd4, 32'h0803, 32'h0, 5'd1, 1'b1, 2'd0, 3'd4, 32'h0020_0200,
      32'h0803, 32'h0800, 1'b1, 1'b0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        side_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] off_reg_i = '0;
  logic [4:0]  imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [2:0]  mod_i = '0;
  logic [31:0] mode_word_i = '0;
  logic        valid_o, wb_en_o, rsvd_mode_o;
  logic [31:0] addr_o, base_new_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .side_i(side_i),
    .reg_idx_i(reg_idx_i), .base_i(base_i), .off_reg_i(off_reg_i),
    .imm_i(imm_i), .use_imm_i(use_imm_i), .size_i(size_i), .mod_i(mod_i),
    .mode_word_i(mode_word_i), .valid_o(valid_o), .addr_o(addr_o),
    .base_new_o(base_new_o), .wb_en_o(wb_en_o), .rsvd_mode_o(rsvd_mode_o)
  );

  task automatic check_out(input string tag, input logic ev,
                           input logic [31:0] ea, input logic [31:0] eb,
                           input logic ew, input logic er);
    n_chk++;
    if (valid_o !== ev || addr_o !== ea || base_new_o !== eb ||
        wb_en_o !== ew || rsvd_mode_o !== er) begin
      n_err++;
      $display("FAIL %s: got v=%b a=%h b=%h wb=%b rs=%b exp v=%b a=%h b=%h wb=%b rs=%b",
               tag, valid_o, addr_o, base_new_o, wb_en_o, rsvd_mode_o,
               ev, ea, eb, ew, er);
    end
  endtask

  task automatic drive(input vec_t v);
    valid_i     = 1'b1;
    side_i      = v.side;
    reg_idx_i   = v.idx;
    base_i      = v.base;
    off_reg_i   = v.offr;
    imm_i       = v.imm;
    use_imm_i   = v.use_imm;
    size_i      = v.size;
    mod_i       = v.mod;
    mode_word_i = v.mw;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R2 reset state", 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check_out($sformatf("R%0d vec %0d", VECS[i].req, i), 1'b1,
                VECS[i].e_addr, VECS[i].e_base, VECS[i].e_wb, VECS[i].e_rsvd);
    end

    // R12: flag lasts one request; R1: idle cycle drops valid and enables
    drive(VECS[5]);
    @(negedge clk);
    check_out("R12 flag set", 1'b1, 32'h010C, 32'h010C, 1'b1, 1'b1);
    valid_i = 1'b0;
    @(negedge clk);
    check_out("R1 idle after request", 1'b0, 32'h010C, 32'h010C, 1'b0, 1'b0);

    // R1: back-to-back requests each appear one cycle later
    drive(VECS[1]);
    @(negedge clk);
    drive(VECS[2]);
    check_out("R1 first of pair", 1'b1, 32'h1FF0, 32'h1FF0, 1'b1, 1'b0);
    @(negedge clk);
    valid_i = 1'b0;
    check_out("R1 second of pair", 1'b1, 32'h3000, 32'h30F8, 1'b1, 1'b0);

    // R2: asynchronous reset mid-run clears outputs
    drive(VECS[5]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out("R2 async reset", 1'b0, 32'h0, 32'h0, 1'b0, 1'b0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule